// File: doc/BRIEF.md
# Multi-Channel Receive DMA Arbiter

This block gathers words from several one-directional receive channels and funnels them into one shared 32-bit memory write port. A channel raises its valid flag together with a data word and an element size. The arbiter grants one channel per clock in rotating order and acknowledges only that channel. It then writes the element to memory at that channel's current pointer.

Each channel keeps a small context: a byte pointer, a count of bytes left, an enable bit and an in-flight flag. Software sets up a channel with three register writes: the pointer, the length, then a start. After that the channel is served without further help until its count runs out. At that point the channel disables itself and pulses an end-of-transfer flag.

The path has two stages. The first stage registers the winner's ID, data and size. The second stage uses the stored ID to read the context, form the address and byte enables, and present the write. A new transfer can be accepted every clock while the memory port is ready.

Top module: `rx_dma_arb`

## Requirements
- R1: At most one bit of `ch_ack_o` is high in any cycle. A bit is high only for a channel whose `ch_valid_i` is high and which is enabled. After reset no channel is acknowledged and `mem_req_o` is low.
- R2: When several channels are eligible, grants rotate. The next grant goes to the first eligible channel after the one granted last, in ascending index order with wrap-around. All channels eligible for 16 cycles therefore gives a strict cyclic order.
- R3: A channel acknowledged before clock edge N has its word on the memory port (`mem_req_o` high) in the cycle that follows edge N. Back-to-back grants give one write per clock.
- R4: `mem_addr_o` is the channel's current byte pointer. After each accepted write the pointer advances by the element size in bytes (1, 2 or 4).
- R5: Element size code 0 means 8 bits, 1 means 16 bits, and 2 means 32 bits. An 8-bit element is copied to all four byte lanes, with the single byte enable at bit `addr[1:0]`. A 16-bit element is copied to both halves, with enables 4'b0011 when `addr[1]` is 0 and 4'b1100 when it is 1. A 32-bit element has enables 4'b1111.
- R6: The register select on `cfg_sel_i` has three values: 0 writes the pointer, 1 writes the byte length, and 2 starts the channel. A channel is never acknowledged before it is started. A start with a length of zero leaves it idle.
- R7: The write that brings a channel's count to zero clears its enable. One clock after that write is accepted, `eot_o` pulses high for one cycle on that channel's bit. The channel is not acknowledged for any element beyond its length, including while its final element is still in the pipeline.
- R8: While `mem_req_o` is high and `mem_ready_i` is low, the address, data and enables hold steady, no channel is acknowledged, and the held word is not replaced.
- R9: Register writes to a channel that is enabled are ignored. Its pointer and length are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ch_valid_i | input | NUM_CH | Per-channel data valid |
| ch_data_i | input | NUM_CH*32 | Per-channel data word, channel c at bits [32c+31:32c] |
| ch_size_i | input | NUM_CH*2 | Per-channel element size code, channel c at bits [2c+1:2c] |
| ch_ack_o | output | NUM_CH | One-hot acknowledge to the winning channel |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | CH_W | Channel targeted by the write |
| cfg_sel_i | input | 2 | Register select: 0 pointer, 1 length, 2 start |
| cfg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Byte address of the write |
| mem_wdata_o | output | 32 | Write data, lanes replicated |
| mem_be_o | output | 4 | Byte enables |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| eot_o | output | NUM_CH | One-cycle end-of-transfer pulse per channel |

## Verification
If a pointer register holds a wrong value, the address is wrong on the first write from that channel, one cycle after its acknowledge. If a count register is wrong, the end-of-transfer pulse comes too early or too late, or an extra acknowledge appears after the final element. A wrong arbiter pointer shows as a break in the grant rotation within one round of all channels. A stage register that is not held during a stall shows as a changed address or data word while ready is low.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  localparam logic [1:0] CFG_PTR = 2'd0;
  localparam logic [1:0] CFG_LEN = 2'd1;
  localparam logic [1:0] CFG_GO  = 2'd2;

  localparam logic [1:0] SZ_B8  = 2'd0;
  localparam logic [1:0] SZ_B16 = 2'd1;

  function automatic logic [2:0] sz_bytes(logic [1:0] sz);
    case (sz)
      SZ_B8:   sz_bytes = 3'd1;
      SZ_B16:  sz_bytes = 3'd2;
      default: sz_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rx_rr_arb.sv
module rx_rr_arb #(
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic [CW-1:0] gnt_idx_o
);
  logic [CW-1:0] last_q;
  logic          found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!found && req_i[(int'(last_q) + k) % N]) begin
        gnt_o[(int'(last_q) + k) % N] = 1'b1;
        found = 1'b1;
      end
    end
  end

  always_comb begin
    gnt_idx_o = '0;
    for (int c = 0; c < N; c++)
      if (gnt_o[c]) gnt_idx_o = CW'(c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= CW'(N - 1);
    else if (|gnt_o) last_q <= gnt_idx_o;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R1
  AST_GNT_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0); // R1
endmodule

// File: rtl/rx_ch_ctx.sv
module rx_ch_ctx import rx_dma_pkg::*; #(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [CW-1:0]               cfg_ch_i,
  input  logic [1:0]                  cfg_sel_i,
  input  logic [31:0]                 cfg_wdata_i,
  input  logic [N-1:0]                gnt_i,
  input  logic                        wr_fire_i,
  input  logic [CW-1:0]               wr_id_i,
  input  logic [2:0]                  wr_bytes_i,
  output logic [N-1:0][ADDR_W-1:0]    ptr_o,
  output logic [N-1:0][LEN_W-1:0]     rem_o,
  output logic [N-1:0]                en_o,
  output logic [N-1:0]                pend_o,
  output logic [N-1:0]                eot_o
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              en_q, pend_q, eot_q;
    logic              cfg_hit, wr_hit, last_wr;

    assign cfg_hit = cfg_we_i && (cfg_ch_i == CW'(c)) && !en_q;
    assign wr_hit  = wr_fire_i && (wr_id_i == CW'(c));
    assign last_wr = wr_hit && (rem_q == LEN_W'(wr_bytes_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q  <= '0;
        rem_q  <= '0;
        en_q   <= 1'b0;
        pend_q <= 1'b0;
        eot_q  <= 1'b0;
      end else begin
        eot_q <= last_wr;
        if (gnt_i[c])    pend_q <= 1'b1;
        else if (wr_hit) pend_q <= 1'b0;
        if (wr_hit) begin
          ptr_q <= ptr_q + ADDR_W'(wr_bytes_i);
          rem_q <= rem_q - LEN_W'(wr_bytes_i);
          if (last_wr) en_q <= 1'b0;
        end else if (cfg_hit) begin
          case (cfg_sel_i)
            CFG_PTR: ptr_q <= ADDR_W'(cfg_wdata_i);
            CFG_LEN: rem_q <= cfg_wdata_i[LEN_W-1:0];
            CFG_GO:  en_q  <= (rem_q != '0);
            default: ;
          endcase
        end
      end
    end

    assign ptr_o[c]  = ptr_q;
    assign rem_o[c]  = rem_q;
    assign en_o[c]   = en_q;
    assign pend_o[c] = pend_q;
    assign eot_o[c]  = eot_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit |-> (rem_q >= LEN_W'(wr_bytes_i))); // R7
    AST_WR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit |-> (en_q && pend_q)); // R7
    AST_EOT_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eot_q |-> !en_q); // R7
  end
endmodule

// File: rtl/rx_wr_lane.sv
module rx_wr_lane import rx_dma_pkg::*; (
  input  logic [1:0]  addr_lo_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] data_i,
  output logic [31:0] wdata_o,
  output logic [3:0]  be_o
);
  always_comb begin
    case (size_i)
      SZ_B8: begin
        wdata_o = {4{data_i[7:0]}};
        be_o    = 4'b0001 << addr_lo_i;
      end
      SZ_B16: begin
        wdata_o = {2{data_i[15:0]}};
        be_o    = addr_lo_i[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        wdata_o = data_i;
        be_o    = 4'b1111;
      end
    endcase
  end
endmodule

// File: rtl/rx_dma_arb.sv
module rx_dma_arb import rx_dma_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    ch_valid_i,
  input  logic [NUM_CH*32-1:0] ch_data_i,
  input  logic [NUM_CH*2-1:0]  ch_size_i,
  output logic [NUM_CH-1:0]    ch_ack_o,
  input  logic                 cfg_we_i,
  input  logic [CH_W-1:0]      cfg_ch_i,
  input  logic [1:0]           cfg_sel_i,
  input  logic [31:0]          cfg_wdata_i,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [31:0]          mem_wdata_o,
  output logic [3:0]           mem_be_o,
  input  logic                 mem_ready_i,
  output logic [NUM_CH-1:0]    eot_o
);
  logic [NUM_CH-1:0][ADDR_W-1:0] ptr;
  logic [NUM_CH-1:0][LEN_W-1:0]  rem;
  logic [NUM_CH-1:0]             en, pend, elig, req, gnt;
  logic [CH_W-1:0]               gnt_idx;

  logic            s1_vld_q;
  logic [CH_W-1:0] s1_id_q;
  logic [31:0]     s1_data_q, sel_data;
  logic [1:0]      s1_size_q, sel_size;
  logic [2:0]      s1_bytes;
  logic            stall, wr_fire;

  assign s1_bytes = sz_bytes(s1_size_q);
  assign stall    = s1_vld_q && !mem_ready_i;
  assign wr_fire  = s1_vld_q && mem_ready_i;

  // mask out bytes already in flight so a channel is never granted past its length
  for (genvar c = 0; c < NUM_CH; c++) begin : g_elig
    logic [LEN_W-1:0] inflt, avail;
    assign inflt   = pend[c] ? LEN_W'(s1_bytes) : '0;
    assign avail   = rem[c] - inflt;
    assign elig[c] = ch_valid_i[c] && en[c] &&
                     (avail >= LEN_W'(sz_bytes(ch_size_i[2*c +: 2])));
  end

  assign req      = stall ? '0 : elig;
  assign ch_ack_o = gnt;

  rx_rr_arb #(.N(NUM_CH)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx)
  );

  always_comb begin
    sel_data = '0;
    sel_size = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (gnt[c]) begin
        sel_data = ch_data_i[32*c +: 32];
        sel_size = ch_size_i[2*c +: 2];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_id_q   <= '0;
      s1_data_q <= '0;
      s1_size_q <= '0;
    end else if (!stall) begin
      s1_vld_q <= |gnt;
      if (|gnt) begin
        s1_id_q   <= gnt_idx;
        s1_data_q <= sel_data;
        s1_size_q <= sel_size;
      end
    end
  end

  rx_ch_ctx #(.N(NUM_CH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_ch_i    (cfg_ch_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .gnt_i       (gnt),
    .wr_fire_i   (wr_fire),
    .wr_id_i     (s1_id_q),
    .wr_bytes_i  (s1_bytes),
    .ptr_o       (ptr),
    .rem_o       (rem),
    .en_o        (en),
    .pend_o      (pend),
    .eot_o       (eot_o)
  );

  assign mem_req_o  = s1_vld_q;
  assign mem_addr_o = ptr[s1_id_q];

  rx_wr_lane u_lane (
    .addr_lo_i (mem_addr_o[1:0]),
    .size_i    (s1_size_q),
    .data_i    (s1_data_q),
    .wdata_o   (mem_wdata_o),
    .be_o      (mem_be_o)
  );

  AST_ACK_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_ack_o) |=> mem_req_o); // R3
  AST_NO_ACK_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |-> (ch_ack_o == '0)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_wdata_o) && $stable(mem_be_o))); // R8
  AST_EOT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eot_o)); // R7
  AST_ACK_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_ack_o & ~(ch_valid_i & en)) == '0); // R1
endmodule

// File: tb/rx_dma_arb_bench.sv
module rx_dma_arb_bench;
  localparam int NC = 4;

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  sz;
    logic [31:0] ptr;
    logic [31:0] dat;
    logic [31:0] wd;
    logic [3:0]  be;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 32'h1000, 32'h0000_00A5, 32'hA5A5_A5A5, 4'b0001},
    '{2'd1, 2'd0, 32'h1003, 32'h0000_003C, 32'h3C3C_3C3C, 4'b1000},
    '{2'd2, 2'd1, 32'h2002, 32'h0000_BEEF, 32'hBEEF_BEEF, 4'b1100},
    '{2'd3, 2'd1, 32'h2000, 32'h0000_1234, 32'h1234_1234, 4'b0011},
    '{2'd0, 2'd2, 32'h3000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b1111},
    '{2'd1, 2'd0, 32'h1001, 32'h0000_FF77, 32'h7777_7777, 4'b0010}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     ch_valid = '0;
  logic [NC*32-1:0]  ch_data = '0;
  logic [NC*2-1:0]   ch_size = '0;
  logic [NC-1:0]     ch_ack;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_ch = '0;
  logic [1:0]        cfg_sel = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              mem_req;
  logic [31:0]       mem_addr, mem_wdata;
  logic [3:0]        mem_be;
  logic              mem_ready = 1'b1;
  logic [NC-1:0]     eot;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  rx_dma_arb u_rx_dma_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .ch_valid_i(ch_valid), .ch_data_i(ch_data), .ch_size_i(ch_size), .ch_ack_o(ch_ack),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_ready_i(mem_ready), .eot_o(eot)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int ch, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_ch(input int ch, input logic [31:0] p, input logic [31:0] len);
    cfg_wr(ch, 2'd0, p);
    cfg_wr(ch, 2'd1, len);
    cfg_wr(ch, 2'd2, 32'd0);
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int prev;
    int cnt [NC];
    logic [NC-1:0] eot_seen;
    int eot_cnt;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ack", 32'(ch_ack), 32'd0);
    chk("R1 reset req", 32'(mem_req), 32'd0);
    chk("R7 reset eot", 32'(eot), 32'd0);

    // table of single-element transfers, each ending its channel
    for (int v = 0; v < NV; v++) begin
      program_ch(int'(VECS[v].ch), VECS[v].ptr, 32'(nbytes(VECS[v].sz)));
      ch_size[2*VECS[v].ch +: 2]  = VECS[v].sz;
      ch_data[32*VECS[v].ch +: 32] = VECS[v].dat;
      ch_valid[VECS[v].ch] = 1'b1;
      #1;
      chk("R1 ack", 32'(ch_ack), 32'(1) << VECS[v].ch);
      @(negedge clk);
      chk("R3 req", 32'(mem_req), 32'd1);
      chk("R4 addr", mem_addr, VECS[v].ptr);
      chk("R5 wdata", mem_wdata, VECS[v].wd);
      chk("R5 be", 32'(mem_be), 32'(VECS[v].be));
      chk("R7 no ack beyond length", 32'(ch_ack), 32'd0);
      @(negedge clk);
      chk("R7 eot", 32'(eot), 32'(1) << VECS[v].ch);
      chk("R7 no ack after end", 32'(ch_ack), 32'd0);
      ch_valid = '0;
    end

    // R2: all channels, 32-bit elements, 16 bytes each
    for (int c = 0; c < NC; c++) begin
      program_ch(c, 32'h4000 + 32'(c) * 32'h100, 32'd16);
      ch_size[2*c +: 2] = 2'd2;
      ch_data[32*c +: 32] = 32'hC0DE_0000 + 32'(c);
      cnt[c] = 0;
    end
    eot_seen = '0;
    eot_cnt = 0;
    ch_valid = '1;
    #1;
    chk("R2 single ack", 32'($countones(ch_ack)), 32'd1);
    prev = 0;
    for (int c = 0; c < NC; c++) if (ch_ack[c]) prev = c;
    for (int k = 1; k < 16; k++) begin
      @(negedge clk);
      eot_cnt += $countones(eot);
      eot_seen |= eot;
      chk("R3 back to back req", 32'(mem_req), 32'd1);
      chk("R4 rr addr", mem_addr, 32'h4000 + 32'(prev) * 32'h100 + 32'(cnt[prev]) * 4);
      cnt[prev]++;
      chk("R2 rotation", 32'(ch_ack), 32'(1) << ((prev + 1) % NC));
      prev = (prev + 1) % NC;
    end
    @(negedge clk);
    eot_cnt += $countones(eot);
    eot_seen |= eot;
    chk("R4 rr last addr", mem_addr, 32'h4000 + 32'(prev) * 32'h100 + 32'(cnt[prev]) * 4);
    chk("R7 ack stops at length", 32'(ch_ack), 32'd0);
    repeat (2) begin
      @(negedge clk);
      eot_cnt += $countones(eot);
      eot_seen |= eot;
    end
    ch_valid = '0;
    chk("R7 eot count", 32'(eot_cnt), 32'd4);
    chk("R7 eot per channel", 32'(eot_seen), 32'hF);

    // R8: stall holds the staged word
    program_ch(1, 32'h500, 32'd8);
    ch_size[3:2] = 2'd2;
    ch_data[63:32] = 32'h1111_1111;
    mem_ready = 1'b0;
    ch_valid[1] = 1'b1;
    #1;
    chk("R8 ack into empty stage", 32'(ch_ack), 32'b0010);
    @(negedge clk);
    ch_data[63:32] = 32'h3333_3333;
    chk("R8 req", 32'(mem_req), 32'd1);
    chk("R8 addr", mem_addr, 32'h500);
    chk("R8 no ack while stalled", 32'(ch_ack), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R8 addr held", mem_addr, 32'h500);
      chk("R8 data held", mem_wdata, 32'h1111_1111);
      chk("R8 no ack held", 32'(ch_ack), 32'd0);
    end
    ch_data[63:32] = 32'h2222_2222;
    mem_ready = 1'b1;
    #1;
    chk("R8 ack on release", 32'(ch_ack), 32'b0010);
    @(negedge clk);
    chk("R4 addr after stall", mem_addr, 32'h504);
    chk("R8 new data", mem_wdata, 32'h2222_2222);
    ch_valid = '0;
    @(negedge clk);
    chk("R7 eot after stall", 32'(eot), 32'b0010);
    chk("R3 idle", 32'(mem_req), 32'd0);

    // R9: writes to an enabled channel are ignored
    program_ch(2, 32'h600, 32'd8);
    cfg_wr(2, 2'd0, 32'h999);
    cfg_wr(2, 2'd1, 32'h40);
    ch_size[5:4] = 2'd2;
    ch_valid[2] = 1'b1;
    #1;
    chk("R9 ack", 32'(ch_ack), 32'b0100);
    @(negedge clk);
    chk("R9 ptr unchanged", mem_addr, 32'h600);
    chk("R9 second ack", 32'(ch_ack), 32'b0100);
    @(negedge clk);
    chk("R4 ptr advance", mem_addr, 32'h604);
    chk("R9 len unchanged", 32'(ch_ack), 32'd0);
    ch_valid = '0;
    @(negedge clk);
    chk("R9 eot at original length", 32'(eot), 32'b0100);

    // R6: zero length start stays idle; no ack before start
    program_ch(3, 32'h700, 32'd0);
    ch_size[7:6] = 2'd2;
    ch_valid[3] = 1'b1;
    #1;
    chk("R6 zero length no ack", 32'(ch_ack), 32'd0);
    cfg_wr(3, 2'd1, 32'd4);
    chk("R6 no ack before start", 32'(ch_ack), 32'd0);
    chk("R6 no req before start", 32'(mem_req), 32'd0);
    cfg_wr(3, 2'd2, 32'd0);
    chk("R6 ack after start", 32'(ch_ack), 32'b1000);
    @(negedge clk);
    chk("R6 addr", mem_addr, 32'h700);
    ch_valid = '0;
    @(negedge clk);
    chk("R6 eot", 32'(eot), 32'b1000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule